// File: doc/BRIEF.md
# Cascadable 4-bit magnitude comparator slice

This block compares two unsigned 4-bit words, `a_i` and `b_i`, and reports on three flags whether `a_i` is greater than, less than or equal to `b_i`. Bit 3 is the most significant bit of each word. The ordering uses magnitude alone, so any code whose values rise with their binary value works, BCD digits included. The slice is purely combinational.

Three tie-break inputs carry a verdict from a less significant slice. Slices chain into a comparator of any word length with no glue logic. Each slice's three flags feed the matching tie-break inputs of the next more significant slice. The least significant slice has its greater and less tie-break inputs tied low and its equal input tied high.

The tie-break inputs matter only when the two local words are equal. Some wide-word schemes drive the tie-break pins with data bits, so every combination of those pins gives a defined result, including the combinations a ripple chain never produces.

Top module: `mag_cmp_slice`

## Requirements
- R1: When `a_i` > `b_i` as unsigned values, `gt_o`=1, `lt_o`=0 and `eq_o`=0, whatever the three tie-break inputs are.
- R2: When `a_i` < `b_i` as unsigned values, `lt_o`=1, `gt_o`=0 and `eq_o`=0, whatever the three tie-break inputs are.
- R3: When `a_i` == `b_i` and `casc_eq_i`=1, only `eq_o` is 1, whatever `casc_gt_i` and `casc_lt_i` are.
- R4: When `a_i` == `b_i` and `casc_eq_i`=0, and exactly one of `casc_gt_i` or `casc_lt_i` is 1, the matching output (`gt_o` or `lt_o`) alone is 1.
- R5: When `a_i` == `b_i` and all three tie-break inputs are 0, `gt_o`=1, `lt_o`=1 and `eq_o`=0.
- R6: When `a_i` == `b_i`, `casc_gt_i`=1, `casc_lt_i`=1 and `casc_eq_i`=0, all three outputs are 0.
- R7: Bit 3 carries the most weight: a word with bit 3 set is greater than any word with bit 3 clear, whatever its lower bits are (for example, 8 > 7).
- R8: Slices chained in ripple order, with the least significant slice's tie-break inputs at greater=0, less=0, equal=1, report the unsigned comparison of the concatenated words. Slice k takes bits 4k+3..4k, and exactly one of the final three flags is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand, bit 3 most significant |
| b_i | input | 4 | Second operand, bit 3 most significant |
| casc_gt_i | input | 1 | Tie-break "greater" verdict from the less significant slice |
| casc_lt_i | input | 1 | Tie-break "less" verdict from the less significant slice |
| casc_eq_i | input | 1 | Tie-break "equal" verdict from the less significant slice |
| gt_o | output | 1 | a_i ranks above b_i |
| lt_o | output | 1 | a_i ranks below b_i |
| eq_o | output | 1 | a_i ranks level with b_i |

## Verification
A single slice is swept over all 256 operand pairs, each paired with all eight tie-break patterns. These vectors show that the tie-break pins have no effect on unequal words. On equal words they separate the five tie-break cases: equal asserted, greater only, less only, both low and both high. Pairs that differ only in bit 3 against the lower bits confirm the weight order. Two slices are then rippled together and swept over every 8-bit operand pair. This pins down how the low slice's verdict passes through a high slice whose own digits tie, and how a deciding high digit overrides the low slice.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_flags_t;

  // Folds the tie-break inputs into a verdict for equal local words.
  // A high equal input wins; otherwise each flag rises unless the opposite
  // tie-break input claims the result.
  function automatic cmp_flags_t fold_tie(input logic cg, input logic cl,
                                          input logic ce);
    cmp_flags_t r;
    if (ce) begin
      r = '{gt: 1'b0, lt: 1'b0, eq: 1'b1};
    end else begin
      r.gt = ~cl;
      r.lt = ~cg;
      r.eq = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/mag_word_order.sv
module mag_word_order #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             a_wins_o,
  output logic             b_wins_o,
  output logic             tie_o
);

  // same_above[i]: every bit above position i-1 matches
  logic [WIDTH:0]   same_above;
  logic [WIDTH-1:0] a_wins_at;
  logic [WIDTH-1:0] b_wins_at;

  assign same_above[WIDTH] = 1'b1;

  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_bit
    assign same_above[i] = same_above[i+1] & (a_i[i] ~^ b_i[i]);
    assign a_wins_at[i]  = same_above[i+1] & a_i[i] & ~b_i[i];
    assign b_wins_at[i]  = same_above[i+1] & ~a_i[i] & b_i[i];
  end

  assign a_wins_o = |a_wins_at;
  assign b_wins_o = |b_wins_at;
  assign tie_o    = same_above[0];

  // Gate-level scan against arithmetic ordering
  always_comb begin
    a_r7_scan_matches_magnitude: assert (a_wins_o == (a_i > b_i) &&
                                         b_wins_o == (a_i < b_i));
    a_r7_one_outcome: assert ($countones({a_wins_o, b_wins_o, tie_o}) == 1);
  end

endmodule

// File: rtl/mag_tie_merge.sv
module mag_tie_merge
  import mag_cmp_pkg::*;
(
  input  logic a_wins_i,
  input  logic b_wins_i,
  input  logic tie_i,
  input  logic casc_gt_i,
  input  logic casc_lt_i,
  input  logic casc_eq_i,
  output logic gt_o,
  output logic lt_o,
  output logic eq_o
);

  cmp_flags_t tie_verdict;
  cmp_flags_t merged;

  assign tie_verdict = fold_tie(casc_gt_i, casc_lt_i, casc_eq_i);

  always_comb begin
    if (a_wins_i)      merged = '{gt: 1'b1, lt: 1'b0, eq: 1'b0};
    else if (b_wins_i) merged = '{gt: 1'b0, lt: 1'b1, eq: 1'b0};
    else               merged = tie_verdict;
  end

  assign gt_o = merged.gt;
  assign lt_o = merged.lt;
  assign eq_o = merged.eq;

  always_comb begin
    if (tie_i && casc_eq_i)
      a_r3_eq_dominates: assert (eq_o && !gt_o && !lt_o);
    if (tie_i && !casc_eq_i && !casc_gt_i && !casc_lt_i)
      a_r5_all_low_both_set: assert (gt_o && lt_o && !eq_o);
    if (tie_i && !casc_eq_i && casc_gt_i && casc_lt_i)
      a_r6_both_high_all_clear: assert (!gt_o && !lt_o && !eq_o);
  end

endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             casc_gt_i,
  input  logic             casc_lt_i,
  input  logic             casc_eq_i,
  output logic             gt_o,
  output logic             lt_o,
  output logic             eq_o
);

  logic word_a_wins;
  logic word_b_wins;
  logic word_tie;

  mag_word_order #(.WIDTH(WIDTH)) u_order (
    .a_i      (a_i),
    .b_i      (b_i),
    .a_wins_o (word_a_wins),
    .b_wins_o (word_b_wins),
    .tie_o    (word_tie)
  );

  mag_tie_merge u_merge (
    .a_wins_i  (word_a_wins),
    .b_wins_i  (word_b_wins),
    .tie_i     (word_tie),
    .casc_gt_i (casc_gt_i),
    .casc_lt_i (casc_lt_i),
    .casc_eq_i (casc_eq_i),
    .gt_o      (gt_o),
    .lt_o      (lt_o),
    .eq_o      (eq_o)
  );

  always_comb begin
    if (a_i > b_i)
      a_r1_greater_ignores_tiebreak: assert (gt_o && !lt_o && !eq_o);
    if (a_i < b_i)
      a_r2_less_ignores_tiebreak: assert (lt_o && !gt_o && !eq_o);
    if (a_i == b_i && !casc_eq_i && (casc_gt_i ^ casc_lt_i))
      a_r4_single_tiebreak_passes: assert (gt_o == casc_gt_i &&
                                           lt_o == casc_lt_i && !eq_o);
  end

endmodule

// File: tb/mag_cmp_slice_test.sv
module mag_cmp_slice_test;

  localparam int W      = 4;
  localparam int NSLICE = 2;
  localparam int CW     = W * NSLICE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // single slice under test
  logic [W-1:0] a, b;
  logic cg, cl, ce;
  logic gt, lt, eq;

  mag_cmp_slice #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .casc_gt_i(cg), .casc_lt_i(cl), .casc_eq_i(ce),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  // ripple chain of slices
  logic [CW-1:0] wa, wb;
  logic [NSLICE:0] rg, rl, re;
  assign rg[0] = 1'b0;
  assign rl[0] = 1'b0;
  assign re[0] = 1'b1;

  for (genvar k = 0; k < NSLICE; k++) begin : ch
    mag_cmp_slice #(.WIDTH(W)) s (
      .a_i(wa[k*W +: W]), .b_i(wb[k*W +: W]),
      .casc_gt_i(rg[k]), .casc_lt_i(rl[k]), .casc_eq_i(re[k]),
      .gt_o(rg[k+1]), .lt_o(rl[k+1]), .eq_o(re[k+1])
    );
  end

  task automatic check3(input string req, input logic [2:0] got,
                        input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got gt/lt/eq=%b expected %b", req, got, exp);
    end
  endtask

  // expected verdict from the requirements, by integer comparison
  function automatic logic [2:0] expect_slice(input int x, input int y,
                                              input logic g, input logic l,
                                              input logic e);
    if (x > y) return 3'b100;
    if (x < y) return 3'b010;
    if (e) return 3'b001;
    case ({g, l})
      2'b10:   return 3'b100;
      2'b01:   return 3'b010;
      2'b00:   return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string req_of(input int x, input int y, input logic g,
                                   input logic l, input logic e);
    if (x > y) return ((x >= 8) && (y < 8)) ? "R7" : "R1";
    if (x < y) return "R2";
    if (e) return "R3";
    if (g ^ l) return "R4";
    if (!g) return "R5";
    return "R6";
  endfunction

  initial begin
    a = '0; b = '0; cg = 1'b0; cl = 1'b0; ce = 1'b1;
    wa = '0; wb = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // initial state: equal zero words with standard tie-break -> equal
    @(negedge clk);
    check3("R3", {gt, lt, eq}, 3'b001);
    check3("R8", {rg[NSLICE], rl[NSLICE], re[NSLICE]}, 3'b001);

    // single slice: every operand pair with every tie-break pattern
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        for (int p = 0; p < 8; p++) begin
          @(posedge clk);
          #1;
          a = x[W-1:0]; b = y[W-1:0];
          {cg, cl, ce} = p[2:0];
          @(negedge clk);
          check3(req_of(x, y, cg, cl, ce), {gt, lt, eq},
                 expect_slice(x, y, cg, cl, ce));
        end
      end
    end

    // R7 corner: msb alone beats all lower bits
    @(posedge clk); #1;
    a = 4'b1000; b = 4'b0111; {cg, cl, ce} = 3'b011;
    @(negedge clk);
    check3("R7", {gt, lt, eq}, 3'b100);

    // R8: rippled chain over every 8-bit operand pair
    for (int x = 0; x < (1 << CW); x++) begin
      for (int y = 0; y < (1 << CW); y++) begin
        @(posedge clk);
        #1;
        wa = x[CW-1:0]; wb = y[CW-1:0];
        @(negedge clk);
        check3("R8", {rg[NSLICE], rl[NSLICE], re[NSLICE]},
               (x > y) ? 3'b100 : ((x < y) ? 3'b010 : 3'b001));
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule